// File: doc/BRIEF.md
# Dual-Output Compare PWM Generator

This block is a 16-bit pulse-width timer with two outputs, A and B. The system clock reaches a time-base counter through two cascaded prescalers: one divides by a power of two, the other by an even step. On each divided tick the counter moves according to one of four modes: up, down, up-down or hold. Each tick also raises up to six events: counter at zero, counter at period, and compare A or compare B matching while the count rises or falls. A per-output action register maps each event to a two-bit action: keep, drive low, drive high or toggle.

Software programs the block through a plain 16-bit register bus. The bus has a write strobe and byte offsets on halfword boundaries. Reads are combinational, so the bus has no back-pressure. Software can also load the counter directly at any time. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `pwm_dual_cmp`

## Requirements
- R1: After reset both outputs are low. The control register reads 0x0003 (hold mode, both dividers at 1). Every other register reads 0.
- R2: Registers by byte offset: control 0x00, counter 0x08, period 0x0A, compare A 0x12, compare B 0x14, action A 0x16, action B 0x18. Each reads back the last value written. Any other offset reads 0, and writing to it changes nothing.
- R3: The tick interval is D1*D2 clocks. D1 is 2 to the power of control[12:10]. D2 is 1 when control[9:7] is 0, and otherwise twice that code. A write to control restarts the prescaler and suppresses the tick of that cycle, so the first tick with the new ratio comes D1*D2 clocks after the write.
- R4: Mode code 0 (control[1:0]) counts up. On a tick the counter goes from the period value to 0, and from any other value it increments modulo 2^16.
- R5: Mode code 1 counts down. On a tick the counter reloads the period from 0, and from any other value it decrements.
- R6: Mode code 2 counts up then down. The direction turns at the period and at 0, the first step after a control write is upward, and a period of 0 holds the count at 0.
- R7: Mode code 3 holds the counter. While it is held, no event changes either output.
- R8: A write to the counter offset loads the count on that clock edge and takes precedence over a tick in the same cycle.
- R9: Both action registers share one field layout: [1:0] zero, [3:2] period, [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling. Code 0 keeps the output, 1 drives it low, 2 drives it high and 3 toggles it. Events are taken from the counter value before the tick. Up mode always counts as rising and down mode as falling.
- R10: When several events fire on one tick, the last one in the order zero, period, compare A, compare B that has a nonzero code sets the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, 3-bit divider selects and a 5-bit offset bus. This allows divide ratios up to 128*14, and the prescaler restart can be tested with mixed ratios such as 4, 6 and 16. Small period values keep many wraps, reversals and compare coincidences within a short run. A compare value of 0 makes the zero event and the compare events land on the same tick, which exercises the priority order.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'd0,
    CM_DOWN = 2'd1,
    CM_UPDN = 2'd2,
    CM_HOLD = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic a_up;
    logic a_dn;
    logic b_up;
    logic b_dn;
  } evt_t;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_CNT  = 'h08;
  localparam int OFF_PRD  = 'h0A;
  localparam int OFF_CMPA = 'h12;
  localparam int OFF_CMPB = 'h14;
  localparam int OFF_ACTA = 'h16;
  localparam int OFF_ACTB = 'h18;

  localparam int MODE_LSB = 0;
  localparam int P2_LSB   = 7;
  localparam int P1_LSB   = 10;
  localparam int ACT_W    = 12;

  function automatic logic act_apply(logic [1:0] code, logic cur, logic prev);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return prev;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int P1_W = 3,
  parameter int P2_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [P1_W-1:0] p1_sel,
  input  logic [P2_W-1:0] p2_sel,
  output logic            tick
);
  localparam int S1_W = (1 << P1_W) - 1;
  localparam int S2_W = P2_W + 1;

  logic [S1_W-1:0] s1_q, s1_lim;
  logic [S2_W-1:0] s2_q, s2_lim;
  logic            s1_end, s2_end;

  assign s1_lim = ~({S1_W{1'b1}} << p1_sel);
  assign s2_lim = (p2_sel == '0) ? '0 : ({p2_sel, 1'b0} - S2_W'(1));
  assign s1_end = (s1_q == s1_lim);
  assign s2_end = (s2_q == s2_lim);
  assign tick   = s1_end && s2_end && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clr) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (s1_end) begin
      s1_q <= '0;
      s2_q <= s2_end ? '0 : s2_q + S2_W'(1);
    end else begin
      s1_q <= s1_q + S1_W'(1);
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (p1_sel != '0 || p2_sel != '0)) |=> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic          restart,
  input  logic [DW-1:0] prd,
  input  logic [DW-1:0] cmpa,
  input  logic [DW-1:0] cmpb,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt,
  output logic          ev_en,
  output evt_t          evt
);
  logic          dir_q, dir_n, rising;
  logic [DW-1:0] cnt_n;

  assign rising = (mode == CM_UP) ? 1'b1 : (mode == CM_DOWN) ? 1'b0 : dir_q;
  assign ev_en  = tick && (mode != CM_HOLD);

  assign evt.zero = (cnt == '0);
  assign evt.prd  = (cnt == prd);
  assign evt.a_up = (cnt == cmpa) && rising;
  assign evt.a_dn = (cnt == cmpa) && !rising;
  assign evt.b_up = (cnt == cmpb) && rising;
  assign evt.b_dn = (cnt == cmpb) && !rising;

  always_comb begin
    cnt_n = cnt;
    dir_n = dir_q;
    if (ld) begin
      cnt_n = ld_val;
    end else if (ev_en) begin
      case (mode)
        CM_UP:   cnt_n = (cnt == prd) ? '0 : cnt + DW'(1);
        CM_DOWN: cnt_n = (cnt == '0) ? prd : cnt - DW'(1);
        CM_UPDN: begin
          if (dir_q) begin
            if (cnt == prd) begin
              dir_n = 1'b0;
              cnt_n = (prd == '0) ? '0 : cnt - DW'(1);
            end else begin
              cnt_n = cnt + DW'(1);
            end
          end else begin
            if (cnt == '0) begin
              dir_n = 1'b1;
              cnt_n = (prd == '0) ? '0 : DW'(1);
            end else begin
              cnt_n = cnt - DW'(1);
            end
          end
        end
        default: cnt_n = cnt;
      endcase
    end
    if (restart) dir_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt   <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_UP && cnt == prd && !ld) |=> (cnt == '0));

  assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_DOWN && cnt == '0 && !ld) |=> (cnt == $past(prd)));

  assert_turn_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_UPDN && rising && cnt == prd && prd != '0 && !ld && !restart)
      |=> (mode != CM_UPDN || !rising));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD && !ld) |=> $stable(cnt));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_en,
  input  evt_t             evt,
  input  logic [ACT_W-1:0] act,
  output logic             out_q
);
  logic nxt;

  always_comb begin
    nxt = out_q;
    if (evt.zero) nxt = act_apply(act[1:0],   out_q, nxt);
    if (evt.prd)  nxt = act_apply(act[3:2],   out_q, nxt);
    if (evt.a_up) nxt = act_apply(act[5:4],   out_q, nxt);
    if (evt.a_dn) nxt = act_apply(act[7:6],   out_q, nxt);
    if (evt.b_up) nxt = act_apply(act[9:8],   out_q, nxt);
    if (evt.b_dn) nxt = act_apply(act[11:10], out_q, nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= 1'b0;
    else if (ev_en) out_q <= nxt;
  end

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_en |=> $stable(out_q));

  assert_cmpb_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en && evt.b_up && act[9:8] == 2'd2) |=> out_q);

  assert_cmpb_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en && evt.b_dn && act[11:10] == 2'd1) |=> !out_q);

endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
  import pwm_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 5,
  parameter int P1_W   = 3,
  parameter int P2_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NOUT = 2;
  localparam logic [DW-1:0] CTRL_RST = DW'(CM_HOLD);

  logic [DW-1:0] ctrl_q, prd_q, cmpa_q, cmpb_q;
  logic [DW-1:0] act_q [NOUT];
  logic [DW-1:0] cnt;
  logic          ctrl_wr, cnt_wr, tick, ev_en;
  evt_t          evt;
  logic [NOUT-1:0] outs;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      prd_q    <= '0;
      cmpa_q   <= '0;
      cmpb_q   <= '0;
      act_q[0] <= '0;
      act_q[1] <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(OFF_CTRL): ctrl_q   <= bus_wdata;
        ADDR_W'(OFF_PRD):  prd_q    <= bus_wdata;
        ADDR_W'(OFF_CMPA): cmpa_q   <= bus_wdata;
        ADDR_W'(OFF_CMPB): cmpb_q   <= bus_wdata;
        ADDR_W'(OFF_ACTA): act_q[0] <= bus_wdata;
        ADDR_W'(OFF_ACTB): act_q[1] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_CTRL): bus_rdata = ctrl_q;
      ADDR_W'(OFF_CNT):  bus_rdata = cnt;
      ADDR_W'(OFF_PRD):  bus_rdata = prd_q;
      ADDR_W'(OFF_CMPA): bus_rdata = cmpa_q;
      ADDR_W'(OFF_CMPB): bus_rdata = cmpb_q;
      ADDR_W'(OFF_ACTA): bus_rdata = act_q[0];
      ADDR_W'(OFF_ACTB): bus_rdata = act_q[1];
      default:           bus_rdata = '0;
    endcase
  end

  pwm_prescale #(.P1_W(P1_W), .P2_W(P2_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ctrl_wr),
    .p1_sel (ctrl_q[P1_LSB +: P1_W]),
    .p2_sel (ctrl_q[P2_LSB +: P2_W]),
    .tick   (tick)
  );

  pwm_timebase #(.DW(DW)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode    (cnt_mode_e'(ctrl_q[MODE_LSB +: 2])),
    .restart (ctrl_wr),
    .prd     (prd_q),
    .cmpa    (cmpa_q),
    .cmpb    (cmpb_q),
    .ld      (cnt_wr),
    .ld_val  (bus_wdata),
    .cnt     (cnt),
    .ev_en   (ev_en),
    .evt     (evt)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    pwm_action u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_en (ev_en),
      .evt   (evt),
      .act   (act_q[g][ACT_W-1:0]),
      .out_q (outs[g])
    );
  end

  assign pwm_a = outs[0];
  assign pwm_b = outs[1];

  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'd3) |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h02)) |=> ($stable(ctrl_q) && $stable(prd_q)));

endmodule

// File: tb/sim_pwm_dual_cmp.sv
`timescale 1ns/100ps
module sim_pwm_dual_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h08;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_a, pwm_b;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [17:0] exp_q[$];

  always #2.5 clk = ~clk;

  pwm_dual_cmp u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // predictor state, written from the requirements
  logic [15:0] m_ctrl, m_prd, m_cmpa, m_cmpb, m_aa, m_ab, m_cnt;
  logic        m_dir, m_a, m_b;
  int          m_pc;

  function automatic logic pick(logic [1:0] c, logic cur, logic prev);
    if (c == 2'd0) return prev;
    if (c == 2'd1) return 1'b0;
    if (c == 2'd2) return 1'b1;
    return ~cur;
  endfunction

  function automatic logic act_next(logic [15:0] act, logic cur, logic z, logic p,
                                    logic au, logic ad, logic bu, logic bd);
    logic r = cur;
    if (z)  r = pick(act[1:0], cur, r);
    if (p)  r = pick(act[3:2], cur, r);
    if (au) r = pick(act[5:4], cur, r);
    if (ad) r = pick(act[7:6], cur, r);
    if (bu) r = pick(act[9:8], cur, r);
    if (bd) r = pick(act[11:10], cur, r);
    return r;
  endfunction

  always @(posedge clk) begin
    int d1, d2;
    logic cw, tk, up, z, p;
    logic [1:0] md;
    if (!rst_n) begin
      m_ctrl = 16'h0003; m_prd = 0; m_cmpa = 0; m_cmpb = 0; m_aa = 0; m_ab = 0;
      m_cnt = 0; m_dir = 1; m_a = 0; m_b = 0; m_pc = 0;
    end else begin
      d1 = 1 << m_ctrl[12:10];
      d2 = (m_ctrl[9:7] == 0) ? 1 : 2 * int'(m_ctrl[9:7]);
      cw = bus_wr && bus_addr == 5'h00;
      tk = (m_pc == d1 * d2 - 1) && !cw;
      m_pc = (cw || tk) ? 0 : m_pc + 1;
      md = m_ctrl[1:0];
      up = (md == 0) ? 1'b1 : (md == 1) ? 1'b0 : m_dir;
      if (tk && md != 3) begin
        z = (m_cnt == 0);
        p = (m_cnt == m_prd);
        m_a = act_next(m_aa, m_a, z, p, m_cnt == m_cmpa && up, m_cnt == m_cmpa && !up,
                       m_cnt == m_cmpb && up, m_cnt == m_cmpb && !up);
        m_b = act_next(m_ab, m_b, z, p, m_cnt == m_cmpa && up, m_cnt == m_cmpa && !up,
                       m_cnt == m_cmpb && up, m_cnt == m_cmpb && !up);
        if (md == 0) m_cnt = p ? 16'd0 : m_cnt + 16'd1;
        else if (md == 1) m_cnt = z ? m_prd : m_cnt - 16'd1;
        else if (m_dir) begin
          if (p) begin m_dir = 0; m_cnt = (m_prd == 0) ? 16'd0 : m_cnt - 16'd1; end
          else m_cnt = m_cnt + 16'd1;
        end else begin
          if (z) begin m_dir = 1; m_cnt = (m_prd == 0) ? 16'd0 : 16'd1; end
          else m_cnt = m_cnt - 16'd1;
        end
      end
      if (cw) m_dir = 1;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_ctrl = bus_wdata;
          5'h08: m_cnt  = bus_wdata;
          5'h0A: m_prd  = bus_wdata;
          5'h12: m_cmpa = bus_wdata;
          5'h14: m_cmpb = bus_wdata;
          5'h16: m_aa   = bus_wdata;
          5'h18: m_ab   = bus_wdata;
          default: ;
        endcase
      end
      exp_q.push_back({m_a, m_b, m_cnt});
    end
  end

  // monitor: pops one predicted item per cycle and compares
  initial begin
    forever begin
      logic [17:0] e;
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        if (rst_n) begin
          n_chk++;
          if (pwm_a !== e[17] || pwm_b !== e[16]) begin
            n_fail++;
            $display("FAIL %s outputs a/b actual %b%b expected %b%b", cur_req,
                     pwm_a, pwm_b, e[17], e[16]);
          end
          if (bus_addr == 5'h08) begin
            n_chk++;
            if (bus_rdata !== e[15:0]) begin
              n_fail++;
              $display("FAIL %s counter actual %0d expected %0d", cur_req, bus_rdata, e[15:0]);
            end
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h08;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp, "read");
    bus_addr = 5'h08;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in %s actual running expected done", cur_req);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic va, vb;
    // R1 reset state
    repeat (2) @(negedge clk);
    #2;
    chk("R1", {15'd0, pwm_a}, 16'd0, "pwm_a in reset");
    chk("R1", {15'd0, pwm_b}, 16'd0, "pwm_b in reset");
    rst_n = 1'b1;
    rd(5'h00, 16'h0003, "R1");
    rd(5'h0A, 16'h0000, "R1");
    rd(5'h16, 16'h0000, "R1");

    // R2 register map and unmapped offsets
    cur_req = "R2";
    wr(5'h0A, 16'h1234); wr(5'h12, 16'hBEEF); wr(5'h14, 16'h0F0F);
    wr(5'h16, 16'h0ABC); wr(5'h18, 16'h0555);
    wr(5'h02, 16'hFFFF); wr(5'h0E, 16'hFFFF);
    rd(5'h0A, 16'h1234, "R2"); rd(5'h12, 16'hBEEF, "R2");
    rd(5'h14, 16'h0F0F, "R2"); rd(5'h16, 16'h0ABC, "R2");
    rd(5'h18, 16'h0555, "R2"); rd(5'h02, 16'h0000, "R2");
    rd(5'h0E, 16'h0000, "R2"); rd(5'h00, 16'h0003, "R2");

    // R4 / R9: up mode, undivided
    do_reset(); cur_req = "R4/R9";
    wr(5'h0A, 16'd9); wr(5'h12, 16'd3); wr(5'h14, 16'd6);
    wr(5'h16, 16'h0012); wr(5'h18, 16'h0102);
    wr(5'h00, 16'h0000);
    repeat (60) @(negedge clk);

    // R5 / R3: down mode, divide 2*2
    do_reset(); cur_req = "R5/R3";
    wr(5'h0A, 16'd9); wr(5'h12, 16'd4); wr(5'h14, 16'd2);
    wr(5'h16, 16'h0048); wr(5'h18, 16'h0402);
    wr(5'h00, 16'h0481);
    repeat (200) @(negedge clk);

    // R6 / R9: up-down mode, divide 6, toggle codes
    do_reset(); cur_req = "R6/R9";
    wr(5'h0A, 16'd7); wr(5'h12, 16'd2); wr(5'h14, 16'd5);
    wr(5'h16, 16'h0003); wr(5'h18, 16'h0F00);
    wr(5'h00, 16'h0182);
    repeat (300) @(negedge clk);

    // R10: coincident zero and compare events
    do_reset(); cur_req = "R10";
    wr(5'h0A, 16'd5); wr(5'h12, 16'd0); wr(5'h14, 16'd0);
    wr(5'h16, 16'h0012); wr(5'h18, 16'h0201);
    wr(5'h00, 16'h0000);
    repeat (30) @(negedge clk);
    #2;
    chk("R10", {15'd0, pwm_a}, 16'd0, "compare A low beats zero high");
    chk("R10", {15'd0, pwm_b}, 16'd1, "compare B high beats zero low");

    // R3: divide 4*4 = 16, restart on control write
    do_reset(); cur_req = "R3";
    wr(5'h0A, 16'd1000);
    wr(5'h00, 16'h0900);
    repeat (40) @(negedge clk);
    rd(5'h08, 16'd2, "R3");

    // R8: counter load while running, then in hold
    cur_req = "R8";
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'd50);
    rd(5'h08, 16'd51, "R8");
    wr(5'h00, 16'h0003);
    wr(5'h08, 16'd7);
    rd(5'h08, 16'd7, "R8");

    // R7: hold mode keeps counter and outputs
    do_reset(); cur_req = "R7";
    wr(5'h0A, 16'd4); wr(5'h16, 16'h0003); wr(5'h18, 16'h000C);
    wr(5'h00, 16'h0000);
    repeat (13) @(negedge clk);
    wr(5'h00, 16'h0003);
    @(negedge clk);
    #2;
    v = bus_rdata; va = pwm_a; vb = pwm_b;
    repeat (12) @(negedge clk);
    rd(5'h08, v, "R7");
    chk("R7", {15'd0, pwm_a}, {15'd0, va}, "pwm_a held");
    chk("R7", {15'd0, pwm_b}, {15'd0, vb}, "pwm_b held");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule